// File: doc/BRIEF.md
# Storage host controller register file

This block is the software-visible register space of a flash storage host controller. It has one 32-bit register port, with address, write strobe, write data, read strobe and registered read data. Behind the port sit several kinds of register:

- fixed identity words: capability, version and two identification words;
- an interrupt status word and its enable mask;
- a controller status word and a controller enable word;
- five error-code words and an aggregation-control word;
- for each of the two work lists (transfers and task-management requests): a 64-bit base address split into low and high words, a doorbell, a clear word and a run-stop word;
- a link command word and three argument words.

Several accesses have side effects. Reading the interrupt status word clears it. Software writes to a doorbell only add bits to it. The command-ready status bit is raised once both list base addresses are nonzero.

A request dispatcher sits next to the block. It sees the live doorbells and the two 64-bit base addresses. It can raise interrupt status bits and retire doorbell bits with single-cycle mask strobes. The register port is a plain strobe interface with no back-pressure. Every access completes in the cycle its strobe is sampled, and a read result is presented one cycle later.

Top module: `shc_regfile`

## Requirements
- R1: Reads of the fixed words return their values. Offset 0x00 returns 0x06070000 OR (NSLOTS AND 0x1F). Offset 0x08 returns 0x00010000. Offset 0x10 returns parameter DEV_ID, and offset 0x14 returns parameter VENDOR_ID.
- R2: After reset, the controller status word (0x30) reads 0x00000008. The doorbells (0x58 transfer, 0x78 task), the command word (0x90) and all four base words read zero. The dispatcher outputs are zero.
- R3: A read strobe sampled at a rising edge loads reg_rdata_o with the addressed word at that edge. reg_rdata_o then holds until the next read strobe. Reads of unmapped or non-word-aligned offsets (for example 0x0C or 0x26) return zero.
- R4: Reading the interrupt status word (0x20) returns its current value and clears it at the same edge. An irq_set_i bit asserted in that same cycle survives the clear and reads 1 afterwards.
- R5: Interrupt status bits are set only by irq_set_i pulses, which accumulate by OR. A software write to 0x20 has no effect.
- R6: A software write to a doorbell ORs the write data into it. Writing zero or a subset never clears a bit.
- R7: A bit set in xfer_db_clr_i or task_db_clr_i clears that doorbell bit at the next edge. This clear wins over a software write that sets the same bit in the same cycle.
- R8: Bit 3 of the controller status word is set after any write to a base word (0x50, 0x54, 0x70, 0x74). It is set only if, once that write has taken effect, the transfer base (high OR low) is nonzero and the task base (high OR low) is nonzero. Otherwise bit 3 is left unchanged.
- R9: Interrupt enable (0x24), controller status (0x30), controller enable (0x34), error codes (0x38 to 0x48), aggregation (0x4C), the clear and run-stop words (0x5C, 0x60, 0x7C, 0x80), the command word (0x90) and the arguments (0x94 to 0x9C) all take the write data unchanged. So do the four base words.
- R10: xfer_base_o is {word 0x54, word 0x50} and task_base_o is {word 0x74, word 0x70}. xfer_db_o and task_db_o show the current doorbells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_en_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_set_i | input | 32 | Dispatcher interrupt status set pulses |
| xfer_db_clr_i | input | 32 | Dispatcher clear mask for the transfer doorbell |
| task_db_clr_i | input | 32 | Dispatcher clear mask for the task doorbell |
| xfer_db_o | output | 32 | Transfer doorbell |
| task_db_o | output | 32 | Task doorbell |
| xfer_base_o | output | 64 | Transfer list base address |
| task_base_o | output | 64 | Task list base address |

## Verification
The properties watch several rules on every cycle:
- no doorbell bit falls without a clear mask, and a masked bit is always zero afterwards;
- interrupt status bits never drop except on a clearing read, and such a read leaves exactly the coincident set pulses;
- read data holds between strobes;
- the ready bit follows any base write that leaves both lists programmed.

Only the bench scenarios show the actual decoded values: the identity words, the reset contents and zero for unmapped offsets. The bench scenarios also cover the concrete ordering cases: a set pulse that collides with a clearing read, a clear mask against a same-cycle write, and the ready bit staying low while only one list is programmed.

// File: rtl/shc_regs_pkg.sv
package shc_regs_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int NLIST  = 2;

  // Byte offsets
  localparam logic [REG_AW-1:0] A_CAP   = 8'h00;
  localparam logic [REG_AW-1:0] A_VER   = 8'h08;
  localparam logic [REG_AW-1:0] A_DEVID = 8'h10;
  localparam logic [REG_AW-1:0] A_VENID = 8'h14;
  localparam logic [REG_AW-1:0] A_ISTS  = 8'h20;
  localparam logic [REG_AW-1:0] A_IEN   = 8'h24;
  localparam logic [REG_AW-1:0] A_HSTS  = 8'h30;
  localparam logic [REG_AW-1:0] A_HEN   = 8'h34;
  localparam logic [REG_AW-1:0] A_ERR0  = 8'h38;
  localparam logic [REG_AW-1:0] A_ERR1  = 8'h3C;
  localparam logic [REG_AW-1:0] A_ERR2  = 8'h40;
  localparam logic [REG_AW-1:0] A_ERR3  = 8'h44;
  localparam logic [REG_AW-1:0] A_ERR4  = 8'h48;
  localparam logic [REG_AW-1:0] A_AGGR  = 8'h4C;
  localparam logic [REG_AW-1:0] A_XBLO  = 8'h50;
  localparam logic [REG_AW-1:0] A_XBHI  = 8'h54;
  localparam logic [REG_AW-1:0] A_XDB   = 8'h58;
  localparam logic [REG_AW-1:0] A_XCLR  = 8'h5C;
  localparam logic [REG_AW-1:0] A_XRUN  = 8'h60;
  localparam logic [REG_AW-1:0] A_TBLO  = 8'h70;
  localparam logic [REG_AW-1:0] A_TBHI  = 8'h74;
  localparam logic [REG_AW-1:0] A_TDB   = 8'h78;
  localparam logic [REG_AW-1:0] A_TCLR  = 8'h7C;
  localparam logic [REG_AW-1:0] A_TRUN  = 8'h80;
  localparam logic [REG_AW-1:0] A_CMD   = 8'h90;
  localparam logic [REG_AW-1:0] A_ARG1  = 8'h94;
  localparam logic [REG_AW-1:0] A_ARG2  = 8'h98;
  localparam logic [REG_AW-1:0] A_ARG3  = 8'h9C;

  // Doorbell offsets, index 0 = transfer list, 1 = task list
  localparam logic [REG_AW-1:0] DB_ADDR [NLIST] = '{8'h58, 8'h78};

  // Slots of the plain read/write bank
  localparam int B_IEN   = 0;
  localparam int B_HEN   = 1;
  localparam int B_ERR0  = 2;
  localparam int B_AGGR  = 7;
  localparam int B_XBLO  = 8;
  localparam int B_XBHI  = 9;
  localparam int B_XCLR  = 10;
  localparam int B_XRUN  = 11;
  localparam int B_TBLO  = 12;
  localparam int B_TBHI  = 13;
  localparam int B_TCLR  = 14;
  localparam int B_TRUN  = 15;
  localparam int B_CMD   = 16;
  localparam int B_ARG1  = 17;
  localparam int B_COUNT = 20;
  localparam int SLOT_W  = $clog2(B_COUNT);

  // Fixed values
  localparam logic [REG_DW-1:0] CAP_BASE  = 32'h0607_0000;
  localparam logic [REG_DW-1:0] CAP_SLOTM = 32'h0000_001F;
  localparam logic [REG_DW-1:0] VER_VAL   = 32'h0001_0000;
  localparam logic [REG_DW-1:0] HSTS_RST  = 32'h0000_0008;
  localparam int                READY_BIT = 3;

  // Maps an offset to its bank slot, -1 when it has none
  function automatic int bank_slot(input logic [REG_AW-1:0] a);
    case (a)
      A_IEN:  return B_IEN;
      A_HEN:  return B_HEN;
      A_ERR0: return B_ERR0;
      A_ERR1: return B_ERR0 + 1;
      A_ERR2: return B_ERR0 + 2;
      A_ERR3: return B_ERR0 + 3;
      A_ERR4: return B_ERR0 + 4;
      A_AGGR: return B_AGGR;
      A_XBLO: return B_XBLO;
      A_XBHI: return B_XBHI;
      A_XCLR: return B_XCLR;
      A_XRUN: return B_XRUN;
      A_TBLO: return B_TBLO;
      A_TBHI: return B_TBHI;
      A_TCLR: return B_TCLR;
      A_TRUN: return B_TRUN;
      A_CMD:  return B_CMD;
      A_ARG1: return B_ARG1;
      A_ARG2: return B_ARG1 + 1;
      A_ARG3: return B_ARG1 + 2;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/shc_rw_bank.sv
module shc_rw_bank #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          wr_sel_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N-1:0][DW-1:0]  q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel_i[i]) q_o[i] <= wdata_i;
      end
    end
  end

  // R9: at most one slot written per cycle
  p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel_i));

  for (genvar g = 0; g < N; g++) begin : g_hold
    // R9: an unselected slot keeps its value
    p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel_i[g] |=> $stable(q_o[g]));
    // R9: a selected slot takes the write data
    p_slot_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel_i[g] |=> q_o[g] == $past(wdata_i));
  end

endmodule

// File: rtl/shc_irq_sts.sv
module shc_irq_sts #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] sts_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_o <= '0;
    else        sts_o <= (rd_clr_i ? '0 : sts_o) | set_i;
  end

  // R4: after a clearing read only the coincident set pulses remain
  p_clear_keeps_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> sts_o == $past(set_i));

  // R5: without a clearing read no bit drops
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> (sts_o & $past(sts_o)) == $past(sts_o));

  // R5: every pulsed bit lands
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> (sts_o & $past(set_i)) == $past(set_i));

endmodule

// File: rtl/shc_doorbell.sv
module shc_doorbell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] db_o
);

  logic [DW-1:0] add;
  assign add = wr_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) db_o <= '0;
    else        db_o <= (db_o | add) & ~clr_i;
  end

  // R6: with no clear mask a doorbell bit never falls
  p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> (db_o & $past(db_o)) == $past(db_o));

  // R7: masked bits are zero afterwards, even against a write
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> (db_o & $past(clr_i)) == '0);

endmodule

// File: rtl/shc_regfile.sv
module shc_regfile
  import shc_regs_pkg::*;
#(
  parameter int          NSLOTS    = 32,
  parameter logic [31:0] DEV_ID    = 32'h5EED_0001,
  parameter logic [31:0] VENDOR_ID = 32'h0000_1D0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_wr_en_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        reg_rd_en_i,
  output logic [31:0] reg_rdata_o,
  input  logic [31:0] irq_set_i,
  input  logic [31:0] xfer_db_clr_i,
  input  logic [31:0] task_db_clr_i,
  output logic [31:0] xfer_db_o,
  output logic [31:0] task_db_o,
  output logic [63:0] xfer_base_o,
  output logic [63:0] task_base_o
);

  localparam logic [REG_DW-1:0] CAP_VAL = CAP_BASE | (32'(NSLOTS) & CAP_SLOTM);

  // ---------------- decode ----------------
  int                        slot;
  logic                      slot_hit;
  logic [SLOT_W-1:0]         slot_idx;
  logic [B_COUNT-1:0]        bank_sel;
  logic [B_COUNT-1:0][REG_DW-1:0] bank_q;

  always_comb begin
    slot     = bank_slot(reg_addr_i);
    slot_hit = (slot >= 0);
    slot_idx = slot[SLOT_W-1:0];
  end

  for (genvar i = 0; i < B_COUNT; i++) begin : g_sel
    assign bank_sel[i] = reg_wr_en_i && slot_hit && (slot_idx == SLOT_W'(i));
  end

  shc_rw_bank #(.N(B_COUNT), .DW(REG_DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel_i (bank_sel),
    .wdata_i  (reg_wdata_i),
    .q_o      (bank_q)
  );

  // ---------------- interrupt status ----------------
  logic              irq_rd_clr;
  logic [REG_DW-1:0] irq_sts;

  assign irq_rd_clr = reg_rd_en_i && (reg_addr_i == A_ISTS);

  shc_irq_sts #(.DW(REG_DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_clr_i (irq_rd_clr),
    .set_i    (irq_set_i),
    .sts_o    (irq_sts)
  );

  // ---------------- doorbells ----------------
  logic [NLIST-1:0][REG_DW-1:0] db_clr;
  logic [NLIST-1:0][REG_DW-1:0] db_q;

  assign db_clr[0] = xfer_db_clr_i;
  assign db_clr[1] = task_db_clr_i;

  for (genvar l = 0; l < NLIST; l++) begin : g_db
    shc_doorbell #(.DW(REG_DW)) u_db (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_en_i && (reg_addr_i == DB_ADDR[l])),
      .wdata_i (reg_wdata_i),
      .clr_i   (db_clr[l]),
      .db_o    (db_q[l])
    );
  end

  assign xfer_db_o = db_q[0];
  assign task_db_o = db_q[1];

  // ---------------- controller status / ready ----------------
  logic [REG_DW-1:0] xblo_n, xbhi_n, tblo_n, tbhi_n;
  logic              base_wr, ready_set;
  logic [REG_DW-1:0] hsts;

  always_comb begin
    xblo_n    = bank_sel[B_XBLO] ? reg_wdata_i : bank_q[B_XBLO];
    xbhi_n    = bank_sel[B_XBHI] ? reg_wdata_i : bank_q[B_XBHI];
    tblo_n    = bank_sel[B_TBLO] ? reg_wdata_i : bank_q[B_TBLO];
    tbhi_n    = bank_sel[B_TBHI] ? reg_wdata_i : bank_q[B_TBHI];
    base_wr   = bank_sel[B_XBLO] | bank_sel[B_XBHI] | bank_sel[B_TBLO] | bank_sel[B_TBHI];
    ready_set = base_wr && (|(xblo_n | xbhi_n)) && (|(tblo_n | tbhi_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   hsts <= HSTS_RST;
    else if (reg_wr_en_i && reg_addr_i == A_HSTS) hsts <= reg_wdata_i;
    else if (ready_set)                           hsts[READY_BIT] <= 1'b1;
  end

  assign xfer_base_o = {bank_q[B_XBHI], bank_q[B_XBLO]};
  assign task_base_o = {bank_q[B_TBHI], bank_q[B_TBLO]};

  // ---------------- read path ----------------
  logic [REG_DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_CAP:   rd_mux = CAP_VAL;
      A_VER:   rd_mux = VER_VAL;
      A_DEVID: rd_mux = DEV_ID;
      A_VENID: rd_mux = VENDOR_ID;
      A_ISTS:  rd_mux = irq_sts;
      A_HSTS:  rd_mux = hsts;
      A_XDB:   rd_mux = db_q[0];
      A_TDB:   rd_mux = db_q[1];
      default: if (slot_hit) rd_mux = bank_q[slot_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           reg_rdata_o <= '0;
    else if (reg_rd_en_i) reg_rdata_o <= rd_mux;
  end

  // R3: read data holds between read strobes
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en_i |=> $stable(reg_rdata_o));

  // R8: a base write leaving both lists programmed raises the ready bit
  p_ready_after_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (!((|xfer_base_o) && (|task_base_o)) || hsts[READY_BIT]));

  // R10: exported bases only move on a write
  p_base_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en_i |=> ($stable(xfer_base_o) && $stable(task_base_o)));

endmodule

// File: tb/sim_shc_regfile.sv
`timescale 1ns/1ps
module sim_shc_regfile;

  localparam int          NSL = 20;
  localparam logic [31:0] DEV = 32'h5EED_0001;
  localparam logic [31:0] VEN = 32'h0000_1D0C;
  localparam int          NV  = 34;

  // {is_write, req, addr, data, expected}
  localparam logic [76:0] VEC [0:NV-1] = '{
    {1'b0, 4'd1, 8'h00, 32'h0, 32'h0607_0014},  // R1 capability
    {1'b0, 4'd1, 8'h08, 32'h0, 32'h0001_0000},  // R1 version
    {1'b0, 4'd1, 8'h10, 32'h0, DEV},            // R1 device id
    {1'b0, 4'd1, 8'h14, 32'h0, VEN},            // R1 vendor id
    {1'b0, 4'd2, 8'h30, 32'h0, 32'h0000_0008},  // R2 status reset
    {1'b0, 4'd2, 8'h58, 32'h0, 32'h0},          // R2 transfer doorbell
    {1'b0, 4'd2, 8'h78, 32'h0, 32'h0},          // R2 task doorbell
    {1'b0, 4'd2, 8'h90, 32'h0, 32'h0},          // R2 command
    {1'b0, 4'd2, 8'h50, 32'h0, 32'h0},          // R2 base
    {1'b0, 4'd2, 8'h74, 32'h0, 32'h0},          // R2 base
    {1'b1, 4'd9, 8'h24, 32'hA5A5_0001, 32'h0},  // R9
    {1'b0, 4'd9, 8'h24, 32'h0, 32'hA5A5_0001},  // R9
    {1'b1, 4'd9, 8'h44, 32'h1357_9BDF, 32'h0},  // R9
    {1'b0, 4'd9, 8'h44, 32'h0, 32'h1357_9BDF},  // R9
    {1'b1, 4'd9, 8'h9C, 32'hCAFE_F00D, 32'h0},  // R9
    {1'b0, 4'd9, 8'h9C, 32'h0, 32'hCAFE_F00D},  // R9
    {1'b0, 4'd3, 8'h0C, 32'h0, 32'h0},          // R3 unmapped
    {1'b0, 4'd3, 8'h26, 32'h0, 32'h0},          // R3 misaligned
    {1'b1, 4'd6, 8'h58, 32'h0000_0005, 32'h0},  // R6
    {1'b1, 4'd6, 8'h58, 32'h0000_0030, 32'h0},  // R6
    {1'b0, 4'd6, 8'h58, 32'h0, 32'h0000_0035},  // R6 accumulates
    {1'b1, 4'd6, 8'h58, 32'h0, 32'h0},          // R6 zero write
    {1'b0, 4'd6, 8'h58, 32'h0, 32'h0000_0035},  // R6 unchanged
    {1'b1, 4'd6, 8'h78, 32'h0000_0080, 32'h0},  // R6
    {1'b1, 4'd6, 8'h78, 32'h0000_0001, 32'h0},  // R6
    {1'b0, 4'd6, 8'h78, 32'h0, 32'h0000_0081},  // R6
    {1'b1, 4'd9, 8'h30, 32'h0, 32'h0},          // R9 status write
    {1'b0, 4'd9, 8'h30, 32'h0, 32'h0},          // R9
    {1'b1, 4'd8, 8'h50, 32'h0000_1000, 32'h0},  // R8 transfer base only
    {1'b0, 4'd8, 8'h30, 32'h0, 32'h0},          // R8 not ready yet
    {1'b1, 4'd8, 8'h74, 32'h0000_0002, 32'h0},  // R8 task base
    {1'b0, 4'd8, 8'h30, 32'h0, 32'h0000_0008},  // R8 ready
    {1'b1, 4'd5, 8'h20, 32'h0000_FFFF, 32'h0},  // R5 write ignored
    {1'b0, 4'd5, 8'h20, 32'h0, 32'h0}           // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, irq_set = '0, xclr = '0, tclr = '0;
  logic [31:0] rdata, xdb, tdb;
  logic [63:0] xbase, tbase;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shc_regfile #(.NSLOTS(NSL), .DEV_ID(DEV), .VENDOR_ID(VEN)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_en_i(wr_en),
    .reg_wdata_i(wdata), .reg_rd_en_i(rd_en), .reg_rdata_o(rdata),
    .irq_set_i(irq_set), .xfer_db_clr_i(xclr), .task_db_clr_i(tclr),
    .xfer_db_o(xdb), .task_db_o(tdb), .xfer_base_o(xbase), .task_base_o(tbase)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_irq(input logic [31:0] m);
    @(negedge clk); irq_set = m;
    @(negedge clk); irq_set = '0;
  endtask

  initial begin
    logic [31:0] v;
    // R2: outputs during reset
    repeat (3) @(negedge clk);
    chk("R2 rdata", {32'h0, rdata}, 64'h0);
    chk("R2 xdb", {xdb, tdb}, 64'h0);
    chk("R2 bases", xbase | tbase, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) begin
        wr(VEC[i][71:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][71:64], v);
        chk($sformatf("R%0d table row %0d", VEC[i][75:72], i), {32'h0, v}, {32'h0, VEC[i][31:0]});
      end
    end

    // R10: dispatcher view
    chk("R10 xfer base", xbase, 64'h0000_0000_0000_1000);
    chk("R10 task base", tbase, 64'h0000_0002_0000_0000);
    chk("R10 doorbells", {xdb, tdb}, {32'h35, 32'h81});

    // R7: clear beats a same-cycle write
    @(negedge clk); addr = 8'h58; wdata = 32'h41; wr_en = 1'b1; xclr = 32'h1;
    @(negedge clk); wr_en = 1'b0; xclr = '0;
    chk("R7 clear wins", {32'h0, xdb}, 64'h74);
    @(negedge clk); tclr = 32'h80;
    @(negedge clk); tclr = '0;
    chk("R7 task clear", {32'h0, tdb}, 64'h01);

    // R4: clear on read
    pulse_irq(32'h4);
    rd(8'h20, v); chk("R4 read value", {32'h0, v}, 64'h4);
    rd(8'h20, v); chk("R4 cleared", {32'h0, v}, 64'h0);
    pulse_irq(32'h1);
    @(negedge clk); addr = 8'h20; rd_en = 1'b1; irq_set = 32'h2;
    @(negedge clk); rd_en = 1'b0; irq_set = '0;
    chk("R4 collide read", {32'h0, rdata}, 64'h1);
    rd(8'h20, v); chk("R4 set kept", {32'h0, v}, 64'h2);

    // R5: pulses accumulate
    pulse_irq(32'h10);
    pulse_irq(32'h20);
    rd(8'h20, v); chk("R5 accumulate", {32'h0, v}, 64'h30);

    // R3: hold between strobes
    rd(8'h24, v);
    repeat (3) @(negedge clk);
    chk("R3 hold", {32'h0, rdata}, 64'hA5A5_0001);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule